// File: doc/BRIEF.md
# Dual-register input capture unit

The block runs a free-running up-counter and snapshots its value into two capture registers when selected transitions appear on two external input pins, A and B. Each pin is first brought into the clock domain by a short synchroniser, then passed through an edge detector. A per-pin 2-bit mode chooses which transitions count: falling, rising, both, or none.

Capture register 2 always follows pin A. Capture register 1 has two sources, chosen by one control bit. In direct mode it follows pin B. In reversed mode it follows pin A, but on the transition opposite to the one configured for pin A. In reversed mode a capture into register 1 raises no interrupt. Pin B edges still raise interrupt 1, so pin B acts as a plain external interrupt. Each interrupt is a one-clock pulse and has its own mask bit.

All configuration sits in one 7-bit control register, loaded through a write-enable and data port.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset, the counter, both capture registers and both interrupts are zero. The control register resets to 7'b0001010: both pin modes 2'b10 (off), source bit 0, masks 0.
- R2: The counter adds one on every clock with `cnt_en` high and holds when it is low. It wraps from 16'hFFFF to 16'h0000.
- R3: Pin mode encodings: 2'b00 falling, 2'b01 rising, 2'b11 both, 2'b10 no edge. With source bit 0, register 2 and interrupt 2 follow pin A under each mode.
- R4: With source bit 0, register 1 captures on every pin B edge selected by pin B's mode, and interrupt 1 pulses on each such capture.
- R5: With source bit 1, register 1 captures on the pin A transition opposite to pin A's mode. Mode 01 captures on falling edges and mode 00 on rising edges. These captures raise no interrupt 1.
- R6: With source bit 1 and pin A mode 2'b11, register 1 never captures.
- R7: With source bit 1, a selected pin B edge pulses interrupt 1 and leaves register 1 unchanged.
- R8: Register 2 and interrupt 2 behave the same whatever the source bit is.
- R9: Each interrupt is a one-clock pulse per event. It is forced low while its mask bit is set.
- R10: Suppose a pin level is first present at clock edge k. Then the capture and the interrupt take effect at edge k+2. The register stores the counter value held just before that edge, not the incremented one.
- R11: Control fields: `ctrl_wdata[1:0]` is pin A mode, [3:2] is pin B mode, [4] is the source bit, [5] masks interrupt 1 and [6] masks interrupt 2. A write takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counter increment enable |
| pin_a | input | 1 | External input A, asynchronous |
| pin_b | input | 1 | External input B, asynchronous |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control register write data |
| cnt_q | output | 16 | Counter value |
| cap1_q | output | 16 | Capture register 1 |
| cap2_q | output | 16 | Capture register 2 |
| irq1 | output | 1 | Interrupt 1, one-clock pulse |
| irq2 | output | 1 | Interrupt 2, one-clock pulse |

## Verification
Pin A is toggled slowly under each of its four modes. The captured counter values show which edge was taken, so falling, rising, both and off can each be told apart.

The same pin A toggles are then repeated with the source bit set. This separates the reversed-phase capture into register 1 from the unchanged register 2 path, and shows that the mode-11 case does nothing.

Pin B toggling in each mode separates the capture path of direct mode from the interrupt-only path of reversed mode. Mask settings and single-cycle pin toggles check the one-clock pulses and the two-cycle latency. A long enabled run crosses the counter wrap.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_OFF  = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       mask2;
    logic       mask1;
    logic       src_rev;
    edge_mode_e mode_b;
    edge_mode_e mode_a;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RESET = '{mask2: 1'b0, mask1: 1'b0, src_rev: 1'b0,
                                   mode_b: EDGE_OFF, mode_a: EDGE_OFF};

  // selected transition according to the pin mode
  function automatic logic edge_hit(edge_mode_e mode, logic rise, logic fall);
    case (mode)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // opposite transition; both-edges and off select nothing
  function automatic logic edge_hit_rev(edge_mode_e mode, logic rise, logic fall);
    case (mode)
      EDGE_FALL: edge_hit_rev = rise;
      EDGE_RISE: edge_hit_rev = fall;
      default:   edge_hit_rev = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dcap_edge_sync.sv
module dcap_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
endmodule

// File: rtl/dcap_counter.sv
module dcap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q + W'(1);
  end
endmodule

// File: rtl/dcap_capture_reg.sv
module dcap_capture_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
  import dcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cap1_q,
  output logic [CNT_W-1:0]  cap2_q,
  output logic              irq1,
  output logic              irq2
);
  localparam int NPINS = 2;
  localparam int NCAPS = 2;

  ctrl_t            ctrl_q;
  logic [NPINS-1:0] pin_raw;
  logic [NPINS-1:0] pin_rise;
  logic [NPINS-1:0] pin_fall;

  // named internal events for the checker
  logic hit_a, hit_b, rev_a;
  logic cap1_evt, cap2_evt, irq1_evt, irq2_evt;
  logic [NCAPS-1:0]       cap_load;
  logic [CNT_W-1:0]       cap_q [NCAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  assign pin_raw = {pin_b, pin_a};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    dcap_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_raw[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  dcap_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .q    (cnt_q)
  );

  assign hit_a = edge_hit(ctrl_q.mode_a, pin_rise[0], pin_fall[0]);
  assign hit_b = edge_hit(ctrl_q.mode_b, pin_rise[1], pin_fall[1]);
  assign rev_a = edge_hit_rev(ctrl_q.mode_a, pin_rise[0], pin_fall[0]);

  assign cap1_evt = ctrl_q.src_rev ? rev_a : hit_b;
  assign irq1_evt = ctrl_q.src_rev ? hit_b : cap1_evt;
  assign cap2_evt = hit_a;
  assign irq2_evt = hit_a;

  assign cap_load = {cap2_evt, cap1_evt};

  for (genvar c = 0; c < NCAPS; c++) begin : g_cap
    dcap_capture_reg #(.W(CNT_W)) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cap_load[c]),
      .d    (cnt_q),
      .q    (cap_q[c])
    );
  end

  assign cap1_q = cap_q[0];
  assign cap2_q = cap_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq1 <= 1'b0;
      irq2 <= 1'b0;
    end else begin
      irq1 <= irq1_evt & ~ctrl_q.mask1;
      irq2 <= irq2_evt & ~ctrl_q.mask2;
    end
  end
endmodule

// File: rtl/dcap_checker.sv
module dcap_checker
  import dcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap1_q,
  input logic [CNT_W-1:0] cap2_q,
  input logic             irq1,
  input logic             irq2,
  input ctrl_t            ctrl_q,
  input logic             rise_a,
  input logic             fall_a,
  input logic             cap1_evt,
  input logic             cap2_evt,
  input logic             hit_b
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  assert_edge_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_a && fall_a));

  assert_cap2_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap2_evt |=> cap2_q == $past(cnt_q));

  assert_cap2_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap2_evt |=> $stable(cap2_q));

  assert_rev_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src_rev && ctrl_q.mode_a == EDGE_BOTH) |=> $stable(cap1_q));

  assert_b_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src_rev && hit_b && !cap1_evt) |=> $stable(cap1_q));

  assert_rev_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src_rev && !hit_b) |=> !irq1);

  assert_mask1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mask1 |=> !irq1);

  assert_mask2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mask2 |=> !irq2);
endmodule

bind dual_capture_unit dcap_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .cnt_q   (cnt_q),
  .cap1_q  (cap1_q),
  .cap2_q  (cap2_q),
  .irq1    (irq1),
  .irq2    (irq2),
  .ctrl_q  (ctrl_q),
  .rise_a  (pin_rise[0]),
  .fall_a  (pin_fall[0]),
  .cap1_evt(cap1_evt),
  .cap2_evt(cap2_evt),
  .hit_b   (hit_b)
);

// File: tb/dual_capture_unit_tb.sv
module dual_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [6:0]  ctrl_wdata = 7'd0;
  logic [15:0] cnt_q, cap1_q, cap2_q;
  logic        irq1, irq2;

  always #4 clk = ~clk;  // 125 MHz

  dual_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_a(pin_a), .pin_b(pin_b),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .cnt_q(cnt_q),
    .cap1_q(cap1_q), .cap2_q(cap2_q), .irq1(irq1), .irq2(irq2)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference model
  int m_cnt, m_cap1, m_cap2;
  bit m_irq1, m_irq2;
  int m_mode_a = 2, m_mode_b = 2;
  bit m_src = 0, m_k1 = 0, m_k2 = 0;
  bit ha[$] = '{0, 0, 0};
  bit hb[$] = '{0, 0, 0};

  function automatic bit selected(int mode, bit now_v, bit before_v);
    bit up   = now_v && !before_v;
    bit down = !now_v && before_v;
    if (mode == 1) return up;
    if (mode == 0) return down;
    if (mode == 3) return up || down;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cap1 = 0; m_cap2 = 0; m_irq1 = 0; m_irq2 = 0;
      m_mode_a = 2; m_mode_b = 2; m_src = 0; m_k1 = 0; m_k2 = 0;
      ha = '{0, 0, 0}; hb = '{0, 0, 0};
    end else begin
      bit ea, eb, ra, c1, i1;
      ea = selected(m_mode_a, ha[1], ha[2]);
      eb = selected(m_mode_b, hb[1], hb[2]);
      // reversed phase: rising config -> falling capture and vice versa
      ra = (m_mode_a == 1) ? selected(0, ha[1], ha[2]) :
           (m_mode_a == 0) ? selected(1, ha[1], ha[2]) : 1'b0;
      c1 = m_src ? ra : eb;
      i1 = m_src ? eb : c1;
      if (c1) m_cap1 = m_cnt;
      if (ea) m_cap2 = m_cnt;
      m_irq1 = i1 && !m_k1;
      m_irq2 = ea && !m_k2;
      if (cnt_en) m_cnt = (m_cnt + 1) % 65536;
      if (ctrl_we) begin
        m_mode_a = ctrl_wdata[1:0]; m_mode_b = ctrl_wdata[3:2];
        m_src = ctrl_wdata[4]; m_k1 = ctrl_wdata[5]; m_k2 = ctrl_wdata[6];
      end
      ha.push_front(pin_a); void'(ha.pop_back());
      hb.push_front(pin_b); void'(hb.pop_back());
    end
  end

  task automatic cmp(string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp("cnt_q", cnt_q, m_cnt);
    cmp("cap1_q", cap1_q, m_cap1);
    cmp("cap2_q", cap2_q, m_cap2);
    cmp("irq1", irq1, m_irq1);
    cmp("irq2", irq2, m_irq2);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // R11 field layout: [1:0] mode A, [3:2] mode B, [4] source, [5] mask1, [6] mask2
  task automatic wr_ctrl(int ma, int mb, bit src, bit k1, bit k2);
    ctrl_we = 1'b1;
    ctrl_wdata = {k2, k1, src, 2'(mb), 2'(ma)};
    tick();
    ctrl_we = 1'b0;
  endtask

  task automatic toggle_a(int n, int hold);
    for (int i = 0; i < n; i++) begin pin_a = ~pin_a; ticks(hold); end
  endtask

  task automatic toggle_b(int n, int hold);
    for (int i = 0; i < n; i++) begin pin_b = ~pin_b; ticks(hold); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    ticks(3);
    rst_n = 1'b1;
    tick();
    cmp("R1 cnt reset", cnt_q, 0);
    cmp("R1 irq reset", irq1 | irq2, 0);
    pin_a = 1'b1; pin_b = 1'b1;  // modes reset to off: no event expected
    ticks(6);
    cmp("R1 cap1 idle", cap1_q, 0);
    cmp("R1 cap2 idle", cap2_q, 0);
    pin_a = 1'b0; pin_b = 1'b0;
    ticks(4);

    cur_req = "R2";
    cnt_en = 1'b1; ticks(10);
    cnt_en = 1'b0; ticks(5);
    cnt_en = 1'b1; ticks(3);

    cur_req = "R3 R11";
    for (int m = 0; m < 4; m++) begin
      wr_ctrl(m, 2, 0, 0, 0);
      toggle_a(4, 7);
    end

    cur_req = "R4";
    for (int m = 0; m < 4; m++) begin
      wr_ctrl(2, m, 0, 0, 0);
      toggle_b(4, 6);
    end

    cur_req = "R5 R8";
    wr_ctrl(1, 2, 1, 0, 0); toggle_a(4, 7);
    wr_ctrl(0, 2, 1, 0, 0); toggle_a(4, 5);

    cur_req = "R6";
    wr_ctrl(3, 2, 1, 0, 0); toggle_a(4, 6);

    cur_req = "R7";
    wr_ctrl(1, 3, 1, 0, 0); toggle_b(4, 6);
    toggle_a(2, 6);

    cur_req = "R9";
    wr_ctrl(3, 3, 0, 1, 0); toggle_a(2, 5); toggle_b(2, 5);
    wr_ctrl(3, 3, 0, 0, 1); toggle_a(2, 5); toggle_b(2, 5);
    wr_ctrl(3, 3, 0, 1, 1); toggle_a(2, 5); toggle_b(2, 5);

    cur_req = "R10";
    wr_ctrl(3, 3, 0, 0, 0);
    toggle_a(6, 1); ticks(4);
    toggle_b(6, 1); ticks(4);
    wr_ctrl(1, 2, 1, 0, 0);
    toggle_a(6, 1); ticks(4);

    cur_req = "R2 wrap";
    wr_ctrl(2, 2, 0, 0, 0);
    cnt_en = 1'b1;
    ticks(65600);
    cur_req = "R3 after wrap";
    wr_ctrl(1, 1, 0, 0, 0);
    pin_a = 1'b1; pin_b = 1'b1; ticks(6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule